// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host port and an asynchronous static RAM of 128K words by 32 bits, organised as four 8-bit lanes. Each lane has its own active-low chip select. All lanes share one active-low write enable and one active-low output enable. The host asks for one word at a time. For a write it supplies an address, the data and a lane mask. For a read it gets the word back on a held read-data port. A one-cycle completion pulse marks the end of each access. Requests are taken only while the ready output is high.

On the memory side the block registers every strobe, the address and the outgoing data. It controls the shared bidirectional data bus through separate output, enable and input signals. Every strobe width is a whole number of clock cycles. Each count is the timing value in picoseconds divided by the clock-period parameter, rounded up, with a minimum of one cycle. With the default 4 ns clock:

- The write overlap lasts 3 cycles.
- The read access lasts 4 cycles.
- The bus turnaround after a read lasts 2 cycles.

A write always lowers write enable one cycle before any chip select falls, and output enable stays high for the whole write. The memory therefore never drives the bus during a write, and the short write pulse rule applies. The lane mask is applied through the per-lane chip selects.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, and whenever ready is high, all four chip selects, write enable and output enable are high (inactive) and the data bus is not driven. Out of reset, ready is 1 and done is 0.
- R2: In a write, write enable falls while all chip selects and output enable are high. The masked chip selects fall one clock later. No chip select ever falls while write enable is still high in a write.
- R3: The write overlap, meaning write enable low together with chip selects low, lasts max(ceil(tWP), ceil(tDW), ceil(tAW), ceil(tWC)-2) cycles, which is 3 at the defaults. At its end, write enable and the chip selects rise on the same edge.
- R4: Chip select bit i (lane i = data bits 8i+7..8i) is asserted during a write only when byte-mask bit i is 1. With an all-zero mask no chip select falls. Lanes that are not selected keep their stored contents.
- R5: The data bus is driven from the edge on which write enable falls until one cycle after it rises. It is never driven while output enable is low.
- R6: The memory address changes only on an edge at which, in the cycle before, write enable and all chip selects were high.
- R7: A read holds all four chip selects and output enable low, with write enable high, for max(ceil(tRC), ceil(tAA)) cycles, which is 4 at the defaults. The bus is captured on the last edge of that window. The read-data port keeps that value until the next read completes.
- R8: done is high for exactly one cycle per access. For a write it rises 5 edges after the accepting edge. For a read it rises 4 edges after the accepting edge.
- R9: After a read, ready stays low for ceil(tHZ) cycles (2 at the defaults) after done, and then rises. After a write, ready is high in the done cycle.
- R10: A request presented while ready is low is ignored. It starts no access and changes no memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, sampled when ready is high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Word address |
| wdata | input | 32 | Write data |
| be | input | 4 | Lane mask for writes, bit i enables lane i |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Last word read, held |
| mem_addr | output | 17 | Memory address |
| mem_cs_n | output | 4 | Per-lane chip selects, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | 32 | Data toward the memory |
| mem_dq_oe | output | 1 | Enables mem_dq_o onto the bus |
| mem_dq_i | input | 32 | Data from the bus |

## Verification
The assertions assume the following about the block's inputs:

- Reset is applied at start-up.
- The memory model answers only while all chip selects and output enable are low and write enable is high.
- Nothing else drives the bus.

The bench's memory model drives a poison word until a read has been active for four half-cycle samples. It updates a lane only where its chip select overlaps write enable while the block drives the bus. Host stimulus is applied away from the clock edge. Stray requests are raised only in cycles where ready is low, so that R10 is exercised.

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl #(
  parameter int CLK_PS  = 4000,
  parameter int AW      = 17,
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int T_RC_PS = 15000,
  parameter int T_AA_PS = 15000,
  parameter int T_WC_PS = 15000,
  parameter int T_WP_PS = 12000,
  parameter int T_AW_PS = 12000,
  parameter int T_DW_PS = 10000,
  parameter int T_HZ_PS = 8000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     wr,
  input  logic [AW-1:0]            addr,
  input  logic [LANES*LANE_W-1:0]  wdata,
  input  logic [LANES-1:0]         be,
  output logic                     ready,
  output logic                     done,
  output logic [LANES*LANE_W-1:0]  rdata,
  output logic [AW-1:0]            mem_addr,
  output logic [LANES-1:0]         mem_cs_n,
  output logic                     mem_we_n,
  output logic                     mem_oe_n,
  output logic [LANES*LANE_W-1:0]  mem_dq_o,
  output logic                     mem_dq_oe,
  input  logic [LANES*LANE_W-1:0]  mem_dq_i
);

  function automatic int cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int WR_PULSE = mx(mx(cyc(T_WP_PS), cyc(T_DW_PS)), mx(cyc(T_AW_PS), cyc(T_WC_PS) - 2));
  localparam int RD_CYC   = mx(cyc(T_RC_PS), cyc(T_AA_PS));
  localparam int TURN_CYC = cyc(T_HZ_PS);
  localparam int CNT_W    = $clog2(mx(mx(WR_PULSE, RD_CYC), TURN_CYC) + 1);

  typedef enum logic [2:0] {S_IDLE, S_WARM, S_WHOLD, S_WREL, S_RACC, S_TURN} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [LANES-1:0] be_q;

  assign ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      be_q      <= '0;
      done      <= 1'b0;
      rdata     <= '0;
      mem_addr  <= '0;
      mem_cs_n  <= '1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          mem_addr <= addr;
          if (wr) begin
            mem_we_n  <= 1'b0;
            mem_dq_oe <= 1'b1;
            mem_dq_o  <= wdata;
            be_q      <= be;
            st        <= S_WARM;
          end else begin
            mem_cs_n <= '0;
            mem_oe_n <= 1'b0;
            cnt      <= CNT_W'(RD_CYC - 1);
            st       <= S_RACC;
          end
        end
        S_WARM: begin
          mem_cs_n <= ~be_q;
          cnt      <= CNT_W'(WR_PULSE - 1);
          st       <= S_WHOLD;
        end
        S_WHOLD: if (cnt == '0) begin
          mem_cs_n <= '1;
          mem_we_n <= 1'b1;
          st       <= S_WREL;
        end else cnt <= cnt - 1'b1;
        S_WREL: begin
          mem_dq_oe <= 1'b0;
          done      <= 1'b1;
          st        <= S_IDLE;
        end
        S_RACC: if (cnt == '0) begin
          rdata    <= mem_dq_i;
          mem_cs_n <= '1;
          mem_oe_n <= 1'b1;
          done     <= 1'b1;
          cnt      <= CNT_W'(TURN_CYC - 1);
          st       <= S_TURN;
        end else cnt <= cnt - 1'b1;
        S_TURN: if (cnt == '0) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_we_n && mem_oe_n && (&mem_cs_n) && !mem_dq_oe)); // R1
  AST_WE_LEADS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ((&mem_cs_n) && mem_oe_n)); // R2
  AST_CS_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(&mem_cs_n) && !(&mem_cs_n) && mem_oe_n) |-> !$past(mem_we_n)); // R2
  AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (&mem_cs_n)); // R3
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R5
  AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mem_we_n) || !(&$past(mem_cs_n))) |-> $stable(mem_addr)); // R6
  AST_READ_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> ((mem_cs_n == '0) && mem_we_n)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

endmodule

// File: tb/sram_strobe_ctrl_test.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_test;

  localparam int WR_LAT = 5;
  localparam int RD_LAT = 4;
  localparam int PULSE  = 3;
  localparam int RD_WIN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [16:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic        ready, done;
  logic [31:0] rdata;
  logic [16:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic        mem_we_n, mem_oe_n, mem_dq_oe;
  logic [31:0] mem_dq_o, mem_dq_i;

  always #2 clk = ~clk;

  sram_strobe_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata), .be(be),
    .ready(ready), .done(done), .rdata(rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int checks = 0, fails = 0;
  bit ended = 0;

  logic [31:0] model [logic [16:0]];
  logic [31:0] refm  [logic [16:0]];

  function automatic logic [31:0] mget(input logic [16:0] a);
    return model.exists(a) ? model[a] : 32'h0;
  endfunction
  function automatic logic [31:0] rget(input logic [16:0] a);
    return refm.exists(a) ? refm[a] : 32'h0;
  endfunction
  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] m);
    logic [31:0] r;
    r = old;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction
  function automatic logic [16:0] pool(input int k);
    return 17'((k * 9973 + 23130) ^ (k << 13));
  endfunction

  int          rd_act = 0;
  logic [31:0] rd_word = '0;
  int          r2_bad = 0, r5_bad = 0, r6_bad = 0;
  int          cs_cyc = 0;
  logic [3:0]  cs_seen = '0;
  logic [16:0] p_addr = '0;
  logic        p_we = 1'b1;
  logic [3:0]  p_cs = 4'hF;

  assign mem_dq_i = (rd_act >= RD_WIN) ? rd_word : 32'hBAD0_BAD0;

  always @(negedge clk) if (rst_n) begin
    logic [31:0] w;
    if (mem_addr != p_addr && (!p_we || p_cs != 4'hF)) r6_bad++;
    if (mem_dq_oe && !mem_oe_n) r5_bad++;
    if (!mem_we_n && !mem_dq_oe) r5_bad++;
    if (p_we && !mem_we_n && (mem_cs_n != 4'hF || !mem_oe_n)) r2_bad++;
    if (p_cs == 4'hF && mem_cs_n != 4'hF && mem_oe_n && p_we) r2_bad++;
    if (!mem_we_n && mem_cs_n != 4'hF) begin
      cs_cyc++;
      cs_seen |= ~mem_cs_n;
      w = mget(mem_addr);
      for (int i = 0; i < 4; i++) if (!mem_cs_n[i] && mem_dq_oe) w[i*8 +: 8] = mem_dq_o[i*8 +: 8];
      model[mem_addr] = w;
    end
    if (!mem_oe_n && mem_cs_n == 4'h0 && mem_we_n && mem_addr == p_addr) begin
      rd_act++;
      rd_word = mget(mem_addr);
    end else if (!mem_oe_n && mem_cs_n == 4'h0 && mem_we_n) begin
      rd_act = 1;
      rd_word = mget(mem_addr);
    end else rd_act = 0;
    p_addr = mem_addr; p_we = mem_we_n; p_cs = mem_cs_n;
  end

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic summary;
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
  endtask

  task automatic wait_ready;
    @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [31:0] d, input logic [3:0] m,
                          input bit junk, input logic [16:0] ja);
    int n;
    wait_ready;
    req = 1; wr = 1; addr = a; wdata = d; be = m;
    cs_cyc = 0; cs_seen = '0;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) begin
        if (junk) begin req = 1; wr = 1; addr = ja; wdata = ~d; be = 4'hF; end
        else req = 0;
      end
      if (n == 3) req = 0;
    end while (!done && n < 60);
    refm[a] = merge(rget(a), d, m);
    chk("R8", "write latency", 32'(n - 1), 32'(WR_LAT));
    chk("R9", "ready in write done cycle", 32'(ready), 32'd1);
    chk("R3", "overlap cycles", 32'(cs_cyc), (m != 0) ? 32'(PULSE) : 32'd0);
    chk("R4", "lanes selected", 32'(cs_seen), 32'(m));
    chk("R4", "stored word", mget(a), rget(a));
    @(negedge clk);
    chk("R8", "done single cycle", 32'(done), 32'd0);
  endtask

  task automatic do_read(input logic [16:0] a);
    int n;
    wait_ready;
    req = 1; wr = 0; addr = a;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) req = 0;
    end while (!done && n < 60);
    chk("R8", "read latency", 32'(n - 1), 32'(RD_LAT));
    chk("R7", "read data", rdata, rget(a));
    chk("R9", "ready low at read done", 32'(ready), 32'd0);
    @(negedge clk);
    chk("R8", "done single cycle", 32'(done), 32'd0);
    chk("R9", "ready low in turnaround", 32'(ready), 32'd0);
    @(negedge clk);
    chk("R9", "ready after turnaround", 32'(ready), 32'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog: actual hang expected completion");
    summary;
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h5EED_0250));
    repeat (4) @(negedge clk);
    chk("R1", "ready in reset", 32'(ready), 32'd1);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "ready", 32'(ready), 32'd1);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "strobes", {27'd0, mem_cs_n, mem_we_n}, 32'h1F);
    chk("R1", "oe and bus", {30'd0, mem_oe_n, mem_dq_oe}, 32'h2);

    do_write(pool(0), 32'h1122_3344, 4'hF, 0, '0);
    do_read(pool(0));
    do_write(pool(0), 32'hAABB_CCDD, 4'b0101, 0, '0);
    do_read(pool(0));
    do_write(pool(0), 32'hFFFF_FFFF, 4'b0000, 0, '0);
    do_read(pool(0));
    do_read(pool(1));
    do_write(pool(2), 32'h0BAD_F00D, 4'b1010, 1, pool(3));
    do_read(pool(3));
    chk("R10", "stray request left word", rdata, 32'h0);
    do_read(pool(2));
    held = rdata;
    do_write(pool(4), 32'h5555_AAAA, 4'hF, 0, '0);
    chk("R7", "read data held across write", rdata, held);

    for (int k = 0; k < 300; k++) begin
      int sel;
      sel = int'($urandom % 16);
      if ($urandom % 3 == 0) do_read(pool(sel));
      else do_write(pool(sel), $urandom, 4'($urandom), ($urandom % 8) == 0, pool(15 - sel));
    end
    for (int k = 0; k < 16; k++) do_read(pool(k));

    chk("R2", "write enable before chip select", 32'(r2_bad), 32'd0);
    chk("R5", "bus drive window", 32'(r5_bad), 32'd0);
    chk("R6", "address moved under strobe", 32'(r6_bad), 32'd0);
    summary;
    $finish;
  end

endmodule